// File: doc/BRIEF.md
# Byte-Lane SRAM Interface Controller

This block sits between a synchronous on-chip host port and an asynchronous 16-bit static RAM. A host request carries a byte address, a 16-bit write word, a two-bit lane enable and a read/write flag. The controller turns each request into one SRAM cycle of fixed length. It drives the active-low and active-high chip selects, the output enable, the write strobe and the two lane strobes. It drives a per-lane output enable for the two 8-bit data lanes, and it returns a one-cycle ready pulse with the read data.

The SRAM can be strapped for 16-bit organisation or for 8-bit organisation. In 16-bit organisation each lane has its own strobe, and the byte enables pick the lanes. In 8-bit organisation only the lower lane carries data, and the lane strobes are parked inactive. The lowest host address bit then leaves on a separate byte-select pin. The pads sit outside the block, so the lanes appear as separate output, output-enable and input vectors.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, the SRAM is deselected. This means sram_cs1_n=1, sram_cs2=0, sram_oe_n=1 and sram_we_n=1, with sram_dq_oe=00 and req_ready=0.
- R2: A request is accepted only on a rising edge where req_valid=1 and the controller is idle. A req_valid seen during an access is dropped, and it leaves no trace in the SRAM contents.
- R3: After the accepting edge, the SRAM stays selected (sram_cs1_n=0, sram_cs2=1) for exactly WAIT_CYC clock cycles. In the cycle that follows, req_ready is high for exactly one cycle and the SRAM is deselected.
- R4: A 16-bit read drives sram_oe_n=0 and sram_we_n=1, with sram_lb_n=!req_be[0] and sram_ub_n=!req_be[1], and drives no lane. rsp_rdata[7:0] returns lane 0 when req_be[0]=1 and zero otherwise. rsp_rdata[15:8] returns lane 1 when req_be[1]=1 and zero otherwise.
- R5: A 16-bit write drives sram_we_n=0 and sram_oe_n=1. The lane strobes follow req_be in the same way as R4. Lane 0 carries req_wdata[7:0] and lane 1 carries req_wdata[15:8], and a lane is driven only when its enable bit is 1.
- R6: A 16-bit access with req_be=00 holds both lane strobes high and drives no lane. It leaves the SRAM unchanged and returns rsp_rdata=0.
- R7: In 8-bit organisation (mode_byte=1 at acceptance), sram_sa=req_addr[0] and sram_lb_n=sram_ub_n=1. Lane 1 is never driven, a write puts req_wdata[7:0] on lane 0, and req_be is ignored.
- R8: An 8-bit read returns the addressed byte on rsp_rdata[7:0] with rsp_rdata[15:8]=0.
- R9: During a write, the enabled lanes are driven in the first WAIT_CYC-1 cycles of the access and released in the last. The lane enables are therefore off one cycle before sram_we_n rises.
- R10: sram_addr equals req_addr[AW:1] in both organisations. In 16-bit organisation sram_sa=0, and a write's response data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_byte | input | 1 | Organisation strap: 1 = 8-bit, 0 = 16-bit |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW+1 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables (bit0 lower lane, bit1 upper lane) |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with req_ready |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_lb_n | output | 1 | Lower lane strobe, active low |
| sram_ub_n | output | 1 | Upper lane strobe, active low |
| sram_sa | output | 1 | Byte select in 8-bit organisation |
| sram_addr | output | AW | Word address |
| sram_dq_o | output | 16 | Data to the lanes |
| sram_dq_oe | output | 2 | Per-lane drive enable |
| sram_dq_i | input | 16 | Data from the lanes |

## Verification
The hardest condition to reach from the ports is a request that arrives while an access is already running. A correct controller shows no reaction to it. The only lasting evidence of a faulty one would be a stray write in the array. The bench therefore raises req_valid for a write to a second address partway through another write, and afterwards reads that second address back. The bench model of the SRAM fills every undriven lane with a non-zero filler byte. Because of this, a disabled lane that leaks into the response shows up as a wrong value rather than an accidental zero.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int LANE_W = 8;
  localparam int N_LANES = 2;
  localparam int DATA_W = LANE_W * N_LANES;

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_DONE} seq_st_e;

  // lanes that take part in an access
  function automatic logic [N_LANES-1:0] lane_mask(input logic byte_md,
                                                   input logic [N_LANES-1:0] be);
    return byte_md ? 2'b01 : be;
  endfunction

  // response word built from the lanes seen on the bus
  function automatic logic [DATA_W-1:0] merge_read(input logic byte_md,
                                                   input logic [N_LANES-1:0] mask,
                                                   input logic [DATA_W-1:0] bus);
    logic [DATA_W-1:0] r;
    if (byte_md) r = {{LANE_W{1'b0}}, bus[LANE_W-1:0]};
    else begin
      r[LANE_W-1:0]      = mask[0] ? bus[LANE_W-1:0]      : '0;
      r[DATA_W-1:LANE_W] = mask[1] ? bus[DATA_W-1:LANE_W] : '0;
    end
    return r;
  endfunction
endpackage

// File: rtl/sram_cyc_seq.sv
module sram_cyc_seq
  import sram_lane_pkg::*;
#(
  parameter int WAIT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic active,
  output logic last_cyc,
  output logic done
);
  localparam int CW = $clog2(WAIT_CYC + 1);

  seq_st_e       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_ACT;
          cnt <= '0;
        end
        ST_ACT: begin
          if (cnt == CW'(WAIT_CYC - 1)) st <= ST_DONE;
          else cnt <= cnt + 1'b1;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle     = (st == ST_IDLE);
  assign active   = (st == ST_ACT);
  assign last_cyc = active && (cnt == CW'(WAIT_CYC - 1));
  assign done     = (st == ST_DONE);

  // R3
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last_cyc));
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && idle);
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_lane_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              active,
  input  logic              last_cyc,
  input  logic              r_write,
  input  logic              r_byte,
  input  logic [N_LANES-1:0] r_mask,
  input  logic [AW:0]       r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic              cs1_n,
  output logic              cs2,
  output logic              oe_n,
  output logic              we_n,
  output logic              lb_n,
  output logic              ub_n,
  output logic              sa,
  output logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] dq_o,
  output logic [N_LANES-1:0] dq_oe
);
  logic drive_win;

  assign cs1_n = !active;
  assign cs2   = active;
  assign oe_n  = !(active && !r_write);
  assign we_n  = !(active && r_write);
  assign lb_n  = !(active && !r_byte && r_mask[0]);
  assign ub_n  = !(active && !r_byte && r_mask[1]);
  assign sa    = r_byte && r_addr[0];
  assign addr  = r_addr[AW:1];
  assign dq_o  = r_byte ? {{LANE_W{1'b0}}, r_wdata[LANE_W-1:0]} : r_wdata;

  // data stays on the lanes up to, but not in, the last access cycle
  assign drive_win = active && r_write && !last_cyc;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign dq_oe[g] = drive_win && r_mask[g];
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW       = 8,
  parameter int WAIT_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_byte,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW:0]   req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          req_ready,
  output logic [15:0]   rsp_rdata,
  output logic          sram_cs1_n,
  output logic          sram_cs2,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic          sram_lb_n,
  output logic          sram_ub_n,
  output logic          sram_sa,
  output logic [AW-1:0] sram_addr,
  output logic [15:0]   sram_dq_o,
  output logic [1:0]    sram_dq_oe,
  input  logic [15:0]   sram_dq_i
);
  logic seq_idle, seq_active, seq_last, seq_done, accept;
  logic r_write, r_byte;
  logic [N_LANES-1:0] r_mask;
  logic [AW:0] r_addr;
  logic [DATA_W-1:0] r_wdata;

  assign accept = req_valid && seq_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_write <= 1'b0;
      r_byte  <= 1'b0;
      r_mask  <= '0;
      r_addr  <= '0;
      r_wdata <= '0;
    end else if (accept) begin
      r_write <= req_write;
      r_byte  <= mode_byte;
      r_mask  <= lane_mask(mode_byte, req_be);
      r_addr  <= req_addr;
      r_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_rdata <= '0;
    else if (seq_last) rsp_rdata <= r_write ? '0 : merge_read(r_byte, r_mask, sram_dq_i);
  end

  assign req_ready = seq_done;

  sram_cyc_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .idle(seq_idle), .active(seq_active), .last_cyc(seq_last), .done(seq_done)
  );

  sram_pin_drive #(.AW(AW)) u_pins (
    .active(seq_active), .last_cyc(seq_last), .r_write(r_write), .r_byte(r_byte),
    .r_mask(r_mask), .r_addr(r_addr), .r_wdata(r_wdata),
    .cs1_n(sram_cs1_n), .cs2(sram_cs2), .oe_n(sram_oe_n), .we_n(sram_we_n),
    .lb_n(sram_lb_n), .ub_n(sram_ub_n), .sa(sram_sa), .addr(sram_addr),
    .dq_o(sram_dq_o), .dq_oe(sram_dq_oe)
  );

  // R1
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_active |-> (sram_cs1_n && !sram_cs2 && sram_oe_n && sram_we_n && sram_dq_oe == 2'b00));
  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seq_idle) |=> $stable(r_addr) && $stable(r_write));
  // R4
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && sram_dq_oe == 2'b00));
  // R5
  lane_strobe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe[1] |-> !sram_ub_n) and (sram_dq_oe[0] |-> (!sram_lb_n || r_byte)));
  // R7
  byte_upper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && r_byte) |-> (sram_lb_n && sram_ub_n && !sram_dq_oe[1]));
  // R9
  release_before_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> ($past(sram_dq_oe) == 2'b00));
endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int WAIT_CYC = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_byte = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready;
  logic [15:0] rsp_rdata;
  logic sram_cs1_n, sram_cs2, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n, sram_sa;
  logic [AW-1:0] sram_addr;
  logic [15:0] sram_dq_o, sram_dq_i;
  logic [1:0] sram_dq_oe;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [15:0] mem [DEPTH];
  logic [15:0] exp_mem [DEPTH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_lane_ctrl #(.AW(AW), .WAIT_CYC(WAIT_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .mode_byte(mode_byte), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .sram_cs1_n(sram_cs1_n),
    .sram_cs2(sram_cs2), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n), .sram_sa(sram_sa),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i)
  );

  function automatic logic [15:0] init_word(int i);
    return 16'(i * 16'h1357) ^ 16'hC3C3;
  endfunction

  // behavioural SRAM: undriven lanes read back as filler 8'hA5
  always_comb begin
    sram_dq_i = 16'hA5A5;
    if (!sram_cs1_n && sram_cs2 && !sram_oe_n && sram_we_n) begin
      if (mode_byte)
        sram_dq_i[7:0] = sram_sa ? mem[sram_addr][15:8] : mem[sram_addr][7:0];
      else begin
        if (!sram_lb_n) sram_dq_i[7:0]  = mem[sram_addr][7:0];
        if (!sram_ub_n) sram_dq_i[15:8] = mem[sram_addr][15:8];
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_word(i);
    end else if (!sram_cs1_n && sram_cs2 && !sram_we_n) begin
      if (mode_byte) begin
        if (sram_dq_oe[0]) begin
          if (sram_sa) mem[sram_addr][15:8] <= sram_dq_o[7:0];
          else         mem[sram_addr][7:0]  <= sram_dq_o[7:0];
        end
      end else begin
        if (!sram_lb_n && sram_dq_oe[0]) mem[sram_addr][7:0]  <= sram_dq_o[7:0];
        if (!sram_ub_n && sram_dq_oe[1]) mem[sram_addr][15:8] <= sram_dq_o[15:8];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic check_idle(input string req);
    check(req, {sram_cs1_n, sram_cs2, sram_oe_n, sram_we_n, sram_dq_oe}, {4'b1011, 2'b00});
    check(req, {31'd0, req_ready}, 32'd0);
  endtask

  // one access; poke_addr >= 0 fires a write request while busy
  task automatic run(input bit wr, input bit bm, input logic [AW:0] a,
                     input logic [15:0] wd, input logic [1:0] be, input int poke_addr);
    logic [1:0] lanes;
    logic [15:0] w, exp_rd;
    w = exp_mem[a[AW:1]];
    lanes = bm ? 2'b01 : be;
    if (bm) exp_rd = {8'h00, a[0] ? w[15:8] : w[7:0]};
    else    exp_rd = {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    if (wr) begin
      exp_rd = 16'h0000;
      if (bm) begin
        if (a[0]) w[15:8] = wd[7:0]; else w[7:0] = wd[7:0];
      end else begin
        if (be[0]) w[7:0]  = wd[7:0];
        if (be[1]) w[15:8] = wd[15:8];
      end
      exp_mem[a[AW:1]] = w;
    end
    mode_byte = bm; req_valid = 1'b1; req_write = wr; req_addr = a;
    req_wdata = wd; req_be = be;
    for (int k = 0; k < WAIT_CYC; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (k == 2) req_valid = 1'b0;
      // R3 selected for WAIT_CYC cycles, no ready
      check("R3", {30'd0, sram_cs1_n, sram_cs2}, 32'b01);
      check("R3", {31'd0, req_ready}, 32'd0);
      check(wr ? "R5" : "R4", {30'd0, sram_oe_n, sram_we_n}, wr ? 32'b10 : 32'b01);
      if (bm) check("R7", {30'd0, sram_lb_n, sram_ub_n}, 32'b11);
      else    check(wr ? "R5" : "R4", {30'd0, sram_lb_n, sram_ub_n}, {30'd0, !be[0], !be[1]});
      check(bm ? "R7" : "R10", {31'd0, sram_sa}, bm ? {31'd0, a[0]} : 32'd0);
      check("R10", 32'(sram_addr), 32'(a[AW:1]));
      check("R9", {30'd0, sram_dq_oe}, (wr && k < WAIT_CYC - 1) ? {30'd0, lanes} : 32'd0);
      if (wr && sram_dq_oe[0]) check("R5", 32'(sram_dq_o[7:0]), 32'(wd[7:0]));
      if (wr && sram_dq_oe[1]) check("R5", 32'(sram_dq_o[15:8]), 32'(wd[15:8]));
      if (k == 1 && poke_addr >= 0) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = (AW+1)'(poke_addr);
        req_wdata = 16'hDEAD; req_be = 2'b11;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    check("R3", {31'd0, req_ready}, 32'd1);
    check("R3", {30'd0, sram_cs1_n, sram_cs2}, 32'b10);
    check(bm ? "R8" : (be == 2'b00 ? "R6" : (wr ? "R10" : "R4")), 32'(rsp_rdata), 32'(exp_rd));
    @(negedge clk);
    check_idle("R3");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    check_idle("R1");
    check(req_ready ? "R1" : "R1", 32'(rsp_rdata), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    // 16-bit organisation
    run(1, 0, 9'h010, 16'h1234, 2'b11, -1);
    run(0, 0, 9'h010, 16'h0000, 2'b11, -1);
    run(1, 0, 9'h010, 16'hAB77, 2'b01, -1);
    run(0, 0, 9'h010, 16'h0000, 2'b11, -1);
    run(1, 0, 9'h022, 16'h9C00, 2'b10, -1);
    run(0, 0, 9'h022, 16'h0000, 2'b01, -1);
    run(0, 0, 9'h022, 16'h0000, 2'b10, -1);
    // R6 empty enables
    run(1, 0, 9'h030, 16'hFFFF, 2'b00, -1);
    run(0, 0, 9'h030, 16'h0000, 2'b00, -1);
    run(0, 0, 9'h030, 16'h0000, 2'b11, -1);
    // R7 R8 8-bit organisation, req_be ignored
    run(1, 1, 9'h041, 16'hEE5A, 2'b00, -1);
    run(1, 1, 9'h040, 16'h3C3C, 2'b10, -1);
    run(0, 1, 9'h041, 16'h0000, 2'b00, -1);
    run(0, 1, 9'h040, 16'h0000, 2'b11, -1);
    run(0, 0, 9'h040, 16'h0000, 2'b11, -1);
    // R2 request while busy is dropped
    run(1, 0, 9'h050, 16'h4455, 2'b11, 9'h062);
    run(0, 0, 9'h062, 16'h0000, 2'b11, -1);
    run(0, 0, 9'h050, 16'h0000, 2'b11, -1);
    // mixed patterns
    begin
      logic [31:0] seed;
      seed = 32'h1ACE;
      for (int i = 0; i < 24; i++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        run(seed[20], seed[21], {1'b0, seed[27:24], seed[5:2]}, seed[31:16], seed[9:8], -1);
      end
    end
    summary();
  end
endmodule